// File: doc/BRIEF.md
# Receive Ring Buffer Page Manager

This block places received frames into a circular region of packet memory. The memory is organised as 256-byte pages. The ring runs from a programmable first page up to, but not including, a programmable end page. A current-page pointer gives the page where the next frame will be placed. A host-owned boundary page marks the oldest page the host has not yet consumed.

The receive side is a byte stream. It carries a valid strobe, a last-byte marker, and CRC and alignment error flags that are valid with the last byte. For each frame the block skips the first four bytes of the current page and streams the payload into memory from offset 4. When the last byte arrives, the block decides whether to keep the frame. If it keeps it, the block returns to the first four bytes and writes a header: status, next-frame page, and a 16-bit count. After that the current-page pointer moves past the frame.

Frames that would run into the boundary page raise an overwrite event and a sticky ring-stopped flag. Frames that arrive in monitor mode, or while that flag is set, are reported as missed and are not stored. Frames with CRC or alignment errors are dropped unless saving them is enabled.

Top module: `rx_ring_pager`

## Requirements
- R1: Register port, 2-bit address. Address 0 is the first page, 1 is the end page, 2 is the boundary and 3 is the current page. Writes take effect on the clock edge. Reads are combinational. After reset the first page is RST_START, the end page is RST_STOP, boundary and current page are both RST_START, and `rst_flag` is 0.
- R2: A stored frame's payload bytes go to consecutive addresses starting at offset 4 of the current page. The header is written at offsets 0 to 3 of that page: offset 0 holds the status byte, 1 the next-frame page, 2 the low byte of (length+4), and 3 the high byte of (length+4).
- R3: When a payload address steps into the end page, it continues at offset 0 of the first page. The next-frame page wraps in the same way.
- R4: A payload byte that would be the first byte of the boundary page is not written. The block pulses `ovw_evt`, sets `rst_flag`, marks the frame missed and discards the rest of it.
- R5: In monitor mode (`cfg_monitor`=1 when the first byte arrives), no byte of the frame is written and the status reports missed.
- R6: While `rst_flag` is 1, frames are reported missed and not written. Writing the boundary with a value different from its current value clears `rst_flag`. Writing the same value leaves it set.
- R7: A frame with a CRC or alignment error produces no header and leaves the current page unchanged, unless `cfg_save_err` is 1. In that case the frame is stored with its error bits in the status byte.
- R8: The status byte has bit0 set for a frame with no error that was not missed, bit1 for a CRC error, bit2 for an alignment error and bit4 for missed. All other bits are 0. `stat_valid` pulses for one cycle, one cycle after the last byte is accepted, with `stat_byte` holding this byte.
- R9: After a stored frame, the current page becomes the page after the last payload page, with R3 wrap applied. Dropped or missed frames leave it unchanged.
- R10: If the page after the last payload page equals the boundary, the frame is handled as an overwrite as in R4.
- R11: `rx_ready` is low for exactly the 4 header-write cycles after a stored frame, and high at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | PAGE_W | Register write data |
| reg_rdata | output | PAGE_W | Register read data |
| cfg_monitor | input | 1 | Check frames but store nothing |
| cfg_save_err | input | 1 | Keep frames with CRC/alignment errors |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Last byte of frame |
| rx_crc_err | input | 1 | CRC error, valid with last byte |
| rx_align_err | input | 1 | Alignment error, valid with last byte |
| rx_ready | output | 1 | Byte accepted when high |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | PAGE_W+8 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| stat_valid | output | 1 | Frame status pulse |
| stat_byte | output | 8 | Frame status byte |
| ovw_evt | output | 1 | Ring overwrite pulse |
| rst_flag | output | 1 | Ring stopped after overwrite |

## Verification
The bench aims at the page edges. Frames end exactly one page short of the boundary, and a byte lands on the first offset of the boundary page. Both would corrupt unread data if the design tested the wrong side of a page. Frames are also run across the end page, where a missing wrap would write outside the ring or give a wrong next-page link in the header. Errored frames are run with and without the save option, and frames arrive in monitor mode and while stopped. A design that advanced the current page on a drop, or wrote while blocked, would show a moved pointer or extra memory writes. Clearing the stopped flag with an unchanged boundary value must not release the ring.

// File: rtl/rx_ring_pager.sv
module rx_ring_pager #(
  parameter int PAGE_W = 8,
  parameter int CNT_W = 16,
  parameter logic [PAGE_W-1:0] RST_START = 'h40,
  parameter logic [PAGE_W-1:0] RST_STOP = 'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [PAGE_W-1:0] reg_wdata,
  output logic [PAGE_W-1:0] reg_rdata,
  input  logic              cfg_monitor,
  input  logic              cfg_save_err,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_crc_err,
  input  logic              rx_align_err,
  output logic              rx_ready,
  output logic              mem_we,
  output logic [PAGE_W+7:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              stat_valid,
  output logic [7:0]        stat_byte,
  output logic              ovw_evt,
  output logic              rst_flag
);
  localparam int AW = PAGE_W + 8;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_DROP, S_HDR} st_t;
  st_t st;

  logic [PAGE_W-1:0] pg_start, pg_stop, pg_bnd, pg_cur, pg_nxt;
  logic [AW-1:0]     wa;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        hidx;
  logic [7:0]        hdr_stat, hdr_byte;

  function automatic logic [PAGE_W-1:0] step_pg(input logic [PAGE_W-1:0] p,
                                                input logic [PAGE_W-1:0] first,
                                                input logic [PAGE_W-1:0] stop);
    logic [PAGE_W-1:0] q;
    q = p + 1'b1;
    return (q == stop) ? first : q;
  endfunction

  function automatic logic [7:0] mk_stat(input logic miss, input logic crc, input logic al);
    return {3'b000, miss, 1'b0, al, crc, ~(miss | crc | al)};
  endfunction

  logic [AW-1:0]     a_now, a_inc, a_adv;
  logic [PAGE_W-1:0] a_pg, end_pg;
  logic [CNT_W-1:0]  cnt_n, cnt4;
  logic take, hit_bnd, blocked, store, end_full, bad;

  assign a_now    = (st == S_IDLE) ? {pg_cur, 8'h04} : wa;
  assign a_pg     = a_now[AW-1:8];
  assign a_inc    = a_now + 1'b1;
  assign a_adv    = (a_inc[7:0] == 8'h00 && a_inc[AW-1:8] == pg_stop) ? {pg_start, 8'h00} : a_inc;
  assign rx_ready = (st != S_HDR);
  assign take     = rx_valid && rx_ready;
  assign hit_bnd  = (st == S_DATA) && (a_now[7:0] == 8'h00) && (a_pg == pg_bnd);
  assign blocked  = cfg_monitor || rst_flag;
  assign store    = take && ((st == S_IDLE && !blocked) || (st == S_DATA && !hit_bnd));
  assign end_pg   = step_pg(a_pg, pg_start, pg_stop);
  assign end_full = (end_pg == pg_bnd);
  assign bad      = rx_crc_err || rx_align_err;
  assign cnt_n    = (st == S_IDLE) ? CNT_W'(1) : cnt + CNT_W'(1);
  assign cnt4     = cnt + CNT_W'(4);

  always_comb begin
    case (hidx)
      2'd0:    hdr_byte = hdr_stat;
      2'd1:    hdr_byte = 8'(pg_nxt);
      2'd2:    hdr_byte = cnt4[7:0];
      default: hdr_byte = cnt4[15:8];
    endcase
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = pg_start;
      2'd1:    reg_rdata = pg_stop;
      2'd2:    reg_rdata = pg_bnd;
      default: reg_rdata = pg_cur;
    endcase
  end

  assign mem_we    = (st == S_HDR) || store;
  assign mem_addr  = (st == S_HDR) ? {pg_cur, 6'd0, hidx} : a_now;
  assign mem_wdata = (st == S_HDR) ? hdr_byte : rx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      pg_start   <= RST_START;
      pg_stop    <= RST_STOP;
      pg_bnd     <= RST_START;
      pg_cur     <= RST_START;
      pg_nxt     <= '0;
      wa         <= '0;
      cnt        <= '0;
      hidx       <= '0;
      hdr_stat   <= '0;
      stat_valid <= 1'b0;
      stat_byte  <= '0;
      ovw_evt    <= 1'b0;
      rst_flag   <= 1'b0;
    end else begin
      stat_valid <= 1'b0;
      ovw_evt    <= 1'b0;
      if (reg_we) begin
        case (reg_addr)
          2'd0: pg_start <= reg_wdata;
          2'd1: pg_stop  <= reg_wdata;
          2'd2: begin
            if (reg_wdata != pg_bnd) rst_flag <= 1'b0;
            pg_bnd <= reg_wdata;
          end
          default: pg_cur <= reg_wdata;
        endcase
      end
      case (st)
        S_IDLE, S_DATA: if (take) begin
          cnt <= cnt_n;
          if (store) begin
            wa <= a_adv;
            if (rx_last) begin
              stat_valid <= 1'b1;
              if (end_full) begin
                stat_byte <= mk_stat(1'b1, rx_crc_err, rx_align_err);
                ovw_evt   <= 1'b1;
                rst_flag  <= 1'b1;
                st        <= S_IDLE;
              end else if (bad && !cfg_save_err) begin
                stat_byte <= mk_stat(1'b0, rx_crc_err, rx_align_err);
                st        <= S_IDLE;
              end else begin
                stat_byte <= mk_stat(1'b0, rx_crc_err, rx_align_err);
                hdr_stat  <= mk_stat(1'b0, rx_crc_err, rx_align_err);
                pg_nxt    <= end_pg;
                hidx      <= 2'd0;
                st        <= S_HDR;
              end
            end else begin
              st <= S_DATA;
            end
          end else begin
            if (hit_bnd) begin
              ovw_evt  <= 1'b1;
              rst_flag <= 1'b1;
            end
            if (rx_last) begin
              stat_valid <= 1'b1;
              stat_byte  <= mk_stat(1'b1, rx_crc_err, rx_align_err);
              st         <= S_IDLE;
            end else begin
              st <= S_DROP;
            end
          end
        end
        S_DROP: if (take && rx_last) begin
          stat_valid <= 1'b1;
          stat_byte  <= mk_stat(1'b1, rx_crc_err, rx_align_err);
          st         <= S_IDLE;
        end
        S_HDR: begin
          hidx <= hidx + 1'b1;
          if (hidx == 2'd3) begin
            pg_cur <= pg_nxt;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_NO_BND_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && st == S_DATA && mem_addr[7:0] == 8'h00) |-> (mem_addr[AW-1:8] != pg_bnd)); // R4
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DROP) |-> !mem_we); // R5
  AST_OVW_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ovw_evt |-> rst_flag); // R6
  AST_CUR_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pg_cur != $past(pg_cur)) && !$past(reg_we && reg_addr == 2'd3)) |-> ($past(st) == S_HDR)); // R9
  AST_READY_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> ($past(st) == S_HDR && $past(hidx) == 2'd3)); // R11
endmodule

// File: tb/sim_rx_ring_pager.sv
`timescale 1ns/1ps
module sim_rx_ring_pager;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic cfg_monitor = 1'b0, cfg_save_err = 1'b0;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_crc_err = 1'b0, rx_align_err = 1'b0, rx_ready;
  logic [7:0] rx_data = '0;
  logic mem_we, stat_valid, ovw_evt, rst_flag;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, stat_byte;

  rx_ring_pager u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_monitor(cfg_monitor),
    .cfg_save_err(cfg_save_err), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_crc_err(rx_crc_err), .rx_align_err(rx_align_err), .rx_ready(rx_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .stat_valid(stat_valid),
    .stat_byte(stat_byte), .ovw_evt(ovw_evt), .rst_flag(rst_flag));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] tbmem [int];
  int nwr = 0, nstat = 0, novw = 0, nrdy = 0;
  logic [7:0] got_stat;
  logic [7:0] dat [0:1023];
  logic [15:0] eaddr [0:1023];
  logic [7:0] m_start, m_stop, m_bnd, m_cur;
  bit m_rst;

  always @(posedge clk) if (rst_n) begin
    if (mem_we) begin tbmem[int'(mem_addr)] = mem_wdata; nwr++; end
    if (stat_valid) begin got_stat = stat_byte; nstat++; end
    if (ovw_evt) novw++;
    if (!rx_ready) nrdy++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] nxt_pg(input logic [7:0] p);
    logic [7:0] q = p + 8'd1;
    return (q == m_stop) ? m_start : q;
  endfunction

  function automatic logic [15:0] nxt_addr(input logic [15:0] a);
    logic [15:0] n = a + 16'd1;
    if (n[7:0] == 8'h00 && n[15:8] == m_stop) n = {m_start, 8'h00};
    return n;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
    case (a)
      2'd0: m_start = v;
      2'd1: m_stop = v;
      2'd2: begin if (v != m_bnd) m_rst = 1'b0; m_bnd = v; end
      default: m_cur = v;
    endcase
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic frame(input int len, input bit crc, input bit al, input bit save,
                       input bit mon, input bit gaps);
    bit miss, ovf, commit, err;
    logic [15:0] a;
    logic [7:0] lastpg, nx, est, v, oldcur;
    logic [15:0] c4;
    int w0, s0, o0, r0, bad;
    miss = mon || m_rst; ovf = 1'b0; a = {m_cur, 8'h04}; lastpg = m_cur; nx = m_cur;
    if (!miss) begin
      for (int i = 0; i < len; i++) begin
        if (i > 0 && a[7:0] == 8'h00 && a[15:8] == m_bnd) begin ovf = 1'b1; break; end
        eaddr[i] = a; lastpg = a[15:8]; a = nxt_addr(a);
      end
      if (!ovf) begin nx = nxt_pg(lastpg); if (nx == m_bnd) ovf = 1'b1; end
    end
    err = crc | al;
    est = {3'b000, miss | ovf, 1'b0, al, crc, ~(miss | ovf | err)};
    commit = !miss && !ovf && (!err || save);
    oldcur = m_cur;
    for (int i = 0; i < len; i++) dat[i] = 8'($urandom);
    w0 = nwr; s0 = nstat; o0 = novw; r0 = nrdy;
    @(negedge clk);
    cfg_monitor = mon; cfg_save_err = save;
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin rx_valid = 1'b0; @(negedge clk); end
      rx_valid = 1'b1; rx_data = dat[i]; rx_last = (i == len - 1);
      rx_crc_err = (i == len - 1) && crc; rx_align_err = (i == len - 1) && al;
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0; rx_crc_err = 1'b0; rx_align_err = 1'b0;
    repeat (8) @(negedge clk);
    chk(nstat == s0 + 1 && got_stat == est, "R8 status byte", got_stat, est);
    chk((novw - o0) == int'(ovf), "R4/R10 overwrite pulses", novw - o0, ovf);
    chk((nrdy - r0) == (commit ? 4 : 0), "R11 ready low cycles", nrdy - r0, commit ? 4 : 0);
    m_rst = m_rst | ovf;
    chk(rst_flag == m_rst, "R6 stopped flag", rst_flag, m_rst);
    if (commit) m_cur = nx;
    rd(2'd3, v);
    chk(v == m_cur, "R9 current page", v, m_cur);
    if (miss) chk(nwr == w0, "R5/R6 no writes when blocked", nwr - w0, 0);
    if (commit) begin
      c4 = 16'(len + 4);
      chk(tbmem[{16'd0, oldcur, 8'h00}] === est && tbmem[{16'd0, oldcur, 8'h01}] === nx &&
          tbmem[{16'd0, oldcur, 8'h02}] === c4[7:0] && tbmem[{16'd0, oldcur, 8'h03}] === c4[15:8],
          "R2 header bytes", tbmem[{16'd0, oldcur, 8'h01}], nx);
      bad = 0;
      for (int i = 0; i < len; i++) if (tbmem[{16'd0, eaddr[i]}] !== dat[i]) bad++;
      chk(bad == 0, "R2/R3 payload bytes", bad, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1; fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int unsigned seed;
    seed = $urandom(32'h1d2c);
    m_start = 8'h40; m_stop = 8'h80; m_bnd = 8'h40; m_cur = 8'h40; m_rst = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, v); chk(v == 8'h40, "R1 reset first page", v, 8'h40);
    rd(2'd1, v); chk(v == 8'h80, "R1 reset end page", v, 8'h80);
    rd(2'd2, v); chk(v == 8'h40, "R1 reset boundary", v, 8'h40);
    rd(2'd3, v); chk(v == 8'h40, "R1 reset current", v, 8'h40);
    chk(rst_flag == 1'b0 && rx_ready == 1'b1, "R1 reset flags", {rst_flag, rx_ready}, 1);
    wr(2'd1, 8'h48);
    rd(2'd1, v); chk(v == 8'h48, "R1 end page readback", v, 8'h48);
    frame(60, 0, 0, 0, 0, 0);
    frame(1, 0, 0, 0, 0, 0);
    frame(300, 0, 0, 0, 0, 1);
    wr(2'd3, 8'h47); wr(2'd2, 8'h43);
    frame(400, 0, 0, 0, 0, 0);                 // R3 wrap into first page
    frame(600, 0, 0, 0, 0, 0);                 // R4 runs into boundary page
    frame(50, 0, 0, 0, 0, 0);                  // R6 missed while stopped
    wr(2'd2, 8'h43);
    chk(rst_flag == 1'b1, "R6 same boundary keeps flag", rst_flag, 1);
    wr(2'd2, 8'h41);
    chk(rst_flag == 1'b0, "R6 new boundary clears flag", rst_flag, 0);
    wr(2'd3, 8'h40); wr(2'd2, 8'h42);
    frame(508, 0, 0, 0, 0, 0);                 // R10 ends one page short of boundary
    wr(2'd2, 8'h44);
    frame(80, 1, 0, 0, 0, 0);                  // R7 dropped
    frame(80, 1, 0, 1, 0, 0);                  // R7 saved
    frame(90, 0, 1, 0, 0, 1);
    frame(70, 0, 0, 0, 1, 0);                  // R5 monitor
    frame(3, 1, 1, 1, 1, 1);
    for (int k = 0; k < 60; k++) begin
      wr(2'd2, 8'(m_start + ($urandom % 8)));
      frame(1 + int'($urandom % 700), ($urandom % 10) == 0, ($urandom % 10) == 0,
            1'($urandom), ($urandom % 12) == 0, 1'($urandom));
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule